// File: doc/BRIEF.md
# Symbol strobe accumulator oscillator

This block is the numerically controlled oscillator of a symbol timing recovery loop. Each clock it adds a programmable nominal increment and the signed, filtered timing error to a wrapping phase accumulator. The phase is never cleared, so any fractional residue carries into the next symbol period. Two one-cycle strobes are taken from rising edges of the top two accumulator bits:

- the strobe from the top bit marks symbol decisions and loop filter updates;
- the strobe from the next bit down runs at twice that rate and paces the timing error detector.

Doubling the increment switches the block from the aligned-quadrature rate plan to the offset-quadrature one, which needs decisions every half symbol. A small sign-capture stage latches the decided I and Q bits on each symbol strobe.

The sample inputs are a free-running stream of one I/Q pair per clock. There is no valid/ready handshake and no back-pressure: every clock carries a new pair, and the upstream filter must present one each cycle. The increment sits in a single addressed configuration register. A run enable freezes the phase when low.

Top module: `symstrobe_nco`

## Requirements
- R1: After reset the phase is 0, both strobes and both decided bits are 0, and the increment register holds RESET_INC (default 1717986918, about 2^34/10).
- R2: On every clock with recover_en high, the 34-bit phase becomes (phase + increment + sign-extended fe) mod 2^34.
- R3: sym_stb is high for exactly one cycle, in the cycle after a clock edge at which phase bit 33 went from 0 to 1.
- R4: ted_stb is high for exactly one cycle, in the cycle after a clock edge at which phase bit 32 went from 0 to 1.
- R5: The phase is never cleared on a strobe. Starting from phase 0 with fe = 0 and increment W < 2^32, the number of sym_stb pulses seen after n enabled clocks is floor((n·W + 2^33) / 2^34), and the number of ted_stb pulses is floor((n·W + 2^32) / 2^33).
- R6: A clock with cfg_we high and cfg_addr equal to INC_ADDR (default 0) loads cfg_data into the increment register, which is used from the next clock on. Writes to any other address leave the increment unchanged.
- R7: On a clock where sym_stb is high, dec_i and dec_q take the sign bits (bit 13) of samp_i and samp_q. On all other clocks they hold their values.
- R8: While recover_en is low, the phase holds its value and both strobes are 0.
- R9: Doubling the increment doubles the sym_stb count over the same interval, within the floor of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_en | input | 1 | Run enable for the phase accumulator and the strobes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_data | input | 34 | Configuration write data |
| fe | input | 20 | Signed filtered timing error |
| samp_i | input | 14 | In-phase sample, two's complement |
| samp_q | input | 14 | Quadrature sample, two's complement |
| sym_stb | output | 1 | Symbol decision / loop filter strobe |
| ted_stb | output | 1 | Timing error detector strobe |
| dec_i | output | 1 | Decided in-phase bit |
| dec_q | output | 1 | Decided quadrature bit |

## Verification
The hardest situation to reach from the ports is a long carried residue that must add up exactly, so that a single lost or extra wrap shows up as a wrong pulse count. Directed runs start from a freshly reset phase with fe held at zero and compare the pulse counts against the closed-form floor, at the nominal increment and at double it. A random phase then mixes run gating, signed error bursts and writes to both the live and the dead addresses. In that phase every cycle is compared against a bench phase model, so stalls that fall across a wrap and increments that change mid-period are covered.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NUM_TAPS = 2;

  function automatic logic [33:0] sext_err(input logic [19:0] e);
    return {{14{e[19]}}, e};
  endfunction
endpackage

// File: rtl/nco_incr_reg.sv
module nco_incr_reg #(
  parameter int unsigned DATA_W = 34,
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] inc_q
);
  logic hit;
  assign hit = we && (addr == MY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   inc_q <= RESET_VAL;
    else if (hit) inc_q <= data;
  end

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == MY_ADDR) |=> $stable(inc_q));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = 34,
  parameter int unsigned FE_W  = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [ACC_W-1:0]       inc,
  input  logic signed [FE_W-1:0] fe,
  output logic [ACC_W-1:0]       acc_q
);
  localparam int unsigned EXT_W = ACC_W - FE_W;

  logic [ACC_W-1:0] fe_ext;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] nxt;

  assign fe_ext = {{EXT_W{fe[FE_W-1]}}, fe};
  assign step   = inc + fe_ext;
  assign nxt    = acc_q + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (run) acc_q <= nxt;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc_q == $past(acc_q)));
endmodule

// File: rtl/nco_edge_strobe.sv
module nco_edge_strobe #(
  parameter int unsigned NUM_TAPS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [NUM_TAPS-1:0] taps,
  output logic [NUM_TAPS-1:0] stb
);
  logic [NUM_TAPS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= taps;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign stb[t] = run & taps[t] & ~prev_q[t];

    // tap 1 is the symbol strobe (R3), tap 0 the detector strobe (R4)
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb[t] |=> !stb[t]);
  end

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (stb == '0));
endmodule

// File: rtl/nco_sign_capture.sv
module nco_sign_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sign_i,
  input  logic sign_q,
  output logic dec_i,
  output logic dec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_i <= 1'b0;
      dec_q <= 1'b0;
    end else if (take) begin
      dec_i <= sign_i;
      dec_q <= sign_q;
    end
  end

  assert_dec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable({dec_i, dec_q}));
endmodule

// File: rtl/symstrobe_nco.sv
module symstrobe_nco #(
  parameter int unsigned ACC_W  = 34,
  parameter int unsigned FE_W   = 20,
  parameter int unsigned SAMP_W = 14,
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] INC_ADDR  = '0,
  parameter logic [ACC_W-1:0]  RESET_INC = 34'd1717986918
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recover_en,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [ACC_W-1:0]        cfg_data,
  input  logic signed [FE_W-1:0]  fe,
  input  logic [SAMP_W-1:0]       samp_i,
  input  logic [SAMP_W-1:0]       samp_q,
  output logic                    sym_stb,
  output logic                    ted_stb,
  output logic                    dec_i,
  output logic                    dec_q
);
  localparam int unsigned TAPS = nco_pkg::NUM_TAPS;

  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] acc;
  logic [TAPS-1:0]  stb;

  nco_incr_reg #(
    .DATA_W(ACC_W), .ADDR_W(ADDR_W), .MY_ADDR(INC_ADDR), .RESET_VAL(RESET_INC)
  ) u_incr (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .data(cfg_data), .inc_q(inc)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .FE_W(FE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(recover_en), .inc(inc), .fe(fe), .acc_q(acc)
  );

  nco_edge_strobe #(.NUM_TAPS(TAPS)) u_edge (
    .clk(clk), .rst_n(rst_n), .run(recover_en),
    .taps(acc[ACC_W-1 -: TAPS]), .stb(stb)
  );

  assign sym_stb = stb[TAPS-1];
  assign ted_stb = stb[TAPS-2];

  nco_sign_capture u_dec (
    .clk(clk), .rst_n(rst_n), .take(sym_stb),
    .sign_i(samp_i[SAMP_W-1]), .sign_q(samp_q[SAMP_W-1]),
    .dec_i(dec_i), .dec_q(dec_q)
  );
endmodule

// File: tb/test_symstrobe_nco.sv
module test_symstrobe_nco;
  localparam int CLK_PERIOD = 10;
  localparam logic [33:0] RST_INC = 34'd1717986918;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_en = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [33:0] cfg_data = '0;
  logic signed [19:0] fe = '0;
  logic [13:0] samp_i = '0, samp_q = '0;
  logic sym_stb, ted_stb, dec_i, dec_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [33:0] m_acc, m_inc;
  logic [1:0]  m_prev;
  logic        m_di, m_dq, cur_en;
  logic        obs_sym, obs_ted;

  always #(CLK_PERIOD/2) clk = ~clk;

  symstrobe_nco i_symstrobe_nco (
    .clk(clk), .rst_n(rst_n), .recover_en(recover_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .fe(fe), .samp_i(samp_i),
    .samp_q(samp_q), .sym_stb(sym_stb), .ted_stb(ted_stb),
    .dec_i(dec_i), .dec_q(dec_q)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 20) $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic longint exp_count(input longint w, input longint n, input longint half);
    return (n * w + half) / (2 * half);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; recover_en = 0; cfg_we = 0; fe = '0;
    @(negedge clk);
    chk(sym_stb == 0 && ted_stb == 0, "R1 strobes in reset", {sym_stb, ted_stb}, 0);
    chk(dec_i == 0 && dec_q == 0, "R1 decided bits in reset", {dec_i, dec_q}, 0);
    rst_n = 1;
    m_acc = '0; m_prev = '0; m_inc = RST_INC; m_di = 0; m_dq = 0; cur_en = 0;
  endtask

  task automatic step(input logic en, input logic we, input logic [1:0] addr,
                      input logic [33:0] data, input logic signed [19:0] f,
                      input logic [13:0] si, input logic [13:0] sq);
    logic es, et, nsym;
    @(negedge clk);
    es = cur_en & m_acc[33] & ~m_prev[1];
    et = cur_en & m_acc[32] & ~m_prev[0];
    obs_sym = sym_stb; obs_ted = ted_stb;
    chk(sym_stb === es, cur_en ? "R2/R3 sym_stb" : "R8 sym_stb idle", sym_stb, es);
    chk(ted_stb === et, cur_en ? "R2/R4 ted_stb" : "R8 ted_stb idle", ted_stb, et);
    chk(dec_i === m_di && dec_q === m_dq, "R7 decided bits", {dec_i, dec_q}, {m_di, m_dq});
    recover_en = en; cfg_we = we; cfg_addr = addr; cfg_data = data;
    fe = f; samp_i = si; samp_q = sq;
    cur_en = en;
    nsym = en & m_acc[33] & ~m_prev[1];
    if (nsym) begin m_di = si[13]; m_dq = sq[13]; end
    m_prev = m_acc[33:32];
    if (en) m_acc = m_acc + m_inc + {{14{f[19]}}, f};
    if (we && addr == 2'd0) m_inc = data;
  endtask

  task automatic count_run(input logic [33:0] w, input bit wr, input int n,
                           input string tag, output int cs, output int ct);
    cs = 0; ct = 0;
    do_reset();
    if (wr) step(0, 1, 2'd0, w, '0, '0, '0);
    for (int i = 0; i <= n; i++) begin
      step(1, 0, 2'd0, '0, '0, 14'($urandom), 14'($urandom));
      if (i >= 1) begin cs += int'(obs_sym); ct += int'(obs_ted); end
    end
    chk(longint'(cs) == exp_count(longint'(w), n, 64'h2_0000_0000), {tag, " sym count"}, cs,
        exp_count(longint'(w), n, 64'h2_0000_0000));
    chk(longint'(ct) == exp_count(longint'(w), n, 64'h1_0000_0000), {tag, " ted count"}, ct,
        exp_count(longint'(w), n, 64'h1_0000_0000));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cs1, ct1, cs2, ct2;
    void'($urandom(32'd4242));
    // R1: default increment from reset, seen through the pulse count
    count_run(RST_INC, 0, 50, "R1 R5", cs1, ct1);
    // R5: nominal rate over a long run, residue carried
    count_run(34'd1717986918, 1, 400, "R5", cs1, ct1);
    // R9: doubled increment doubles the decision rate
    count_run(34'd3435973836, 1, 400, "R9", cs2, ct2);
    chk(cs2 == 2 * cs1, "R9 doubled rate", cs2, 2 * cs1);
    // R6: writes to a dead address change nothing
    do_reset();
    step(0, 1, 2'd1, 34'd5, '0, '0, '0);
    step(0, 1, 2'd3, 34'd5, '0, '0, '0);
    for (int i = 0; i <= 100; i++) begin
      step(1, 0, 2'd0, '0, '0, '0, '0);
      if (i >= 1) cs1 += int'(obs_sym);
    end
    chk(m_inc == RST_INC, "R6 increment after dead writes", longint'(m_inc), longint'(RST_INC));
    // R8: long stall with error applied, phase must hold
    for (int i = 0; i < 40; i++) step(0, 0, 2'd0, '0, 20'sd3000, 14'h2000, 14'h2000);
    for (int i = 0; i < 40; i++) step(1, 0, 2'd0, '0, '0, 14'h2000, 14'h1000);
    // R2: negative error and a live increment write mid-period
    step(1, 1, 2'd0, 34'd3000000000, -20'sd4000, 14'h3fff, 14'h0001);
    for (int i = 0; i < 60; i++) step(1, 0, 2'd0, '0, -20'sd500000, 14'($urandom), 14'($urandom));
    // random mixture
    for (int i = 0; i < 3000; i++) begin
      logic [33:0] w;
      w = 34'(32'h2000_0000 + ($urandom % 32'hD000_0000));
      step(($urandom % 8) != 0, ($urandom % 16) == 0, 2'($urandom), w,
           20'(int'($urandom % 8192) - 4096), 14'($urandom), 14'($urandom));
    end
    do_reset();
    step(0, 0, 2'd0, '0, '0, '0, '0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule